// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a global history register. The register holds the outcomes of the most recent `HIST_W` resolved branches, with the newest outcome in bit 0. It also keeps a table of `2**IDX_W` rows, and the row is chosen by the branch PC. Each row holds `2**HIST_W` saturating counters of `CTR_W` bits. The current history value picks one of these counters, and that counter's most significant bit is the prediction. Because every branch shares the same history, the outcome of one branch decides which counter another branch uses.

The fetch side presents a PC on the lookup port. It receives the prediction at once, together with the history value that was used to make it. The pipeline carries that history value with the branch. When the branch resolves, the pipeline returns the PC, the real outcome and the saved history value on the update port. In that clock edge the block trains the selected counter and shifts the outcome into the history register. Test configurations are (HIST_W, CTR_W) = (2,2) and (1,1).

Top module: `corr_predictor`

## Requirements
- R1: After reset every counter is zero, so every lookup predicts not taken, and the history register reads zero.
- R2: Each accepted update shifts the history left by one place and puts the outcome into bit 0 (1 = taken). The oldest bit is dropped. Without an update the history does not change.
- R3: The table row is PC bits [2+IDX_W-1:2]. PCs that differ only in bits [1:0], or only above bit 2+IDX_W-1, give the same prediction.
- R4: Within a row, the counter at index `lk_hist` gives the prediction. Training one history index does not change the prediction made under any other history index.
- R5: A counter counts up on a taken update and stops at its all-ones value. The prediction is taken when the counter's top bit is 1. For 2-bit counters, two taken updates from zero are needed before the prediction is taken. After saturation, one not-taken update still leaves the prediction taken.
- R6: A counter counts down on a not-taken update and stops at zero. From a counter saturated at zero, a single taken update does not turn a 2-bit counter's prediction to taken.
- R7: An update writes only the counter addressed by `upd_pc` and `upd_hist`. The history value currently held in the register plays no part in selecting it.
- R8: In the (1,1) setup, take two branches in different rows. Their outcomes follow a repeating pattern: both are taken in one pass, then both are not taken in the next. Mispredictions then occur only in the first pass, two in total over four passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | PC of the branch being predicted |
| lk_hist | output | HIST_W | Global history used for this lookup; carried to the update |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_hist | input | HIST_W | History value returned from the branch's lookup |
| upd_taken | input | 1 | Real outcome, 1 = taken |

## Verification
If a counter has the wrong value, `lk_taken` is wrong on the next lookup that reaches that row and history index. The error can stay hidden until the history register steers a lookup to that counter, so the tests force each history value before they read a prediction. If the history register is wrong, it shows on `lk_hist` in the cycle right after the update, and it moves lookups to counters that were never trained. An error in the row or index decode shows as training that appears under the wrong PC or the wrong history.

// File: rtl/corr_pred_pkg.sv
package corr_pred_pkg;
  typedef enum logic {
    DIR_NOT_TAKEN = 1'b0,
    DIR_TAKEN     = 1'b1
  } dir_e;

  localparam int unsigned WORD_OFFS = 2;
endpackage

// File: rtl/corr_hist_reg.sv
module corr_hist_reg #(
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_q
);
  logic [HIST_W-1:0] hist_d;

  generate
    if (HIST_W > 1) begin : g_multi
      always_comb begin
        hist_d = {hist_q[HIST_W-2:0], bit_in};
      end

      AST_HIST_AGES: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])); // R2
    end else begin : g_one
      always_comb begin
        hist_d = bit_in;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_d;
    end
  end

  AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist_q[0] == $past(bit_in)); // R2
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q)); // R2
endmodule

// File: rtl/corr_sat_ctr.sv
module corr_sat_ctr #(
  parameter int unsigned CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             up,
  output logic [CTR_W-1:0] ctr_q
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] CTR_MIN = '0;

  logic [CTR_W-1:0] ctr_d;

  always_comb begin
    ctr_d = ctr_q;
    if (up && ctr_q != CTR_MAX) begin
      ctr_d = ctr_q + 1'b1;
    end else if (!up && ctr_q != CTR_MIN) begin
      ctr_d = ctr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= CTR_MIN;
    end else if (en) begin
      ctr_q <= ctr_d;
    end
  end

  AST_CTR_TOP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && up && ctr_q == CTR_MAX) |=> ctr_q == CTR_MAX); // R5
  AST_CTR_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && up && ctr_q != CTR_MAX) |=> ctr_q == $past(ctr_q) + 1'b1); // R5
  AST_CTR_BOT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !up && ctr_q == CTR_MIN) |=> ctr_q == CTR_MIN); // R6
  AST_CTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(ctr_q)); // R7
endmodule

// File: rtl/corr_predictor.sv
module corr_predictor #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned HIST_W = 2,
  parameter int unsigned CTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic [HIST_W-1:0] lk_hist,
  output logic              lk_taken,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken
);
  import corr_pred_pkg::*;

  localparam int unsigned ROWS  = 1 << IDX_W;
  localparam int unsigned SLOTS = 1 << HIST_W;
  localparam int unsigned CELLS = ROWS * SLOTS;

  logic [IDX_W-1:0]  lk_row;
  logic [IDX_W-1:0]  upd_row;
  logic [CELLS-1:0]  cell_en;
  logic [CTR_W-1:0]  cell_val [CELLS];
  logic [CTR_W-1:0]  sel_val;
  dir_e              upd_dir;

  always_comb begin
    lk_row  = lk_pc[WORD_OFFS +: IDX_W];
    upd_row = upd_pc[WORD_OFFS +: IDX_W];
    upd_dir = dir_e'(upd_taken);
  end

  corr_hist_reg #(.HIST_W(HIST_W)) hist_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd_valid),
    .bit_in   (upd_dir == DIR_TAKEN),
    .hist_q   (lk_hist)
  );

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam int unsigned CELL = r * SLOTS + s;

        always_comb begin
          cell_en[CELL] = upd_valid
                       && (upd_row == IDX_W'(r))
                       && (upd_hist == HIST_W'(s));
        end

        corr_sat_ctr #(.CTR_W(CTR_W)) ctr_i (
          .clk   (clk),
          .rst_n (rst_n),
          .en    (cell_en[CELL]),
          .up    (upd_dir == DIR_TAKEN),
          .ctr_q (cell_val[CELL])
        );
      end
    end
  endgenerate

  always_comb begin
    sel_val  = cell_val[{lk_row, lk_hist}];
    lk_taken = sel_val[CTR_W-1];
  end

  AST_ONE_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cell_en)); // R7
  AST_UPD_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $countones(cell_en) == 1); // R7
endmodule

// File: tb/corr_predictor_tb.sv
module corr_predictor_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ROW_SPAN   = 64;

  logic        clk;
  logic        rst_n;
  logic [31:0] lk_pc, upd_pc;
  logic [1:0]  lk_hist, upd_hist;
  logic        lk_taken, upd_valid, upd_taken;

  logic [31:0] b_lk_pc, b_upd_pc;
  logic [0:0]  b_lk_hist, b_upd_hist;
  logic        b_lk_taken, b_upd_valid, b_upd_taken;

  int tests_run;
  int tests_failed;

  corr_predictor #(.PC_W(32), .IDX_W(4), .HIST_W(2), .CTR_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hist(lk_hist),
    .lk_taken(lk_taken), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_hist(upd_hist), .upd_taken(upd_taken)
  );

  corr_predictor #(.PC_W(32), .IDX_W(4), .HIST_W(1), .CTR_W(1)) dut11_i (
    .clk(clk), .rst_n(rst_n), .lk_pc(b_lk_pc), .lk_hist(b_lk_hist),
    .lk_taken(b_lk_taken), .upd_valid(b_upd_valid), .upd_pc(b_upd_pc),
    .upd_hist(b_upd_hist), .upd_taken(b_upd_taken)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    tests_run++;
    if (act != exp) begin
      tests_failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic upd(input logic [31:0] pc, input logic t, input logic [1:0] h);
    upd_pc = pc; upd_taken = t; upd_hist = h; upd_valid = 1'b1;
    @(posedge clk); #1;
    upd_valid = 1'b0;
  endtask

  task automatic set_hist(input logic [1:0] h);
    upd(32'h3C, h[1], 2'd0);
    upd(32'h3C, h[0], 2'd0);
  endtask

  function automatic int predict_at(input logic [31:0] pc);
    return int'(lk_taken);
  endfunction

  task automatic look(input logic [31:0] pc, input logic [1:0] h, input string req, input int exp);
    set_hist(h);
    lk_pc = pc; #1;
    chk(req, int'(lk_hist), int'(h));
    chk(req, int'(lk_taken), exp);
  endtask

  task automatic t_reset();
    lk_pc = 32'h0; #1;
    chk("R1 hist", int'(lk_hist), 0);
    for (int i = 0; i < 16; i++) begin
      lk_pc = 32'(i * 4); #1;
      chk("R1 pred", int'(lk_taken), 0);
    end
  endtask

  task automatic t_history();
    upd(32'h60, 1'b1, 2'd0); chk("R2 after T", int'(lk_hist), 1);
    upd(32'h60, 1'b0, 2'd0); chk("R2 after NT", int'(lk_hist), 2);
    upd(32'h60, 1'b1, 2'd0); chk("R2 after T", int'(lk_hist), 1);
    @(posedge clk); #1;      chk("R2 hold", int'(lk_hist), 1);
  endtask

  task automatic t_count_up();
    upd(32'h40, 1'b1, 2'd0); look(32'h40, 2'd0, "R5 one up", 0);
    upd(32'h40, 1'b1, 2'd0); look(32'h40, 2'd0, "R5 two up", 1);
    for (int i = 0; i < 3; i++) upd(32'h40, 1'b1, 2'd0);
    upd(32'h40, 1'b0, 2'd0); look(32'h40, 2'd0, "R5 sat then one down", 1);
    upd(32'h40, 1'b0, 2'd0); look(32'h40, 2'd0, "R5 two down", 0);
  endtask

  task automatic t_count_down();
    for (int i = 0; i < 3; i++) upd(32'h44, 1'b0, 2'd0);
    upd(32'h44, 1'b1, 2'd0); look(32'h44, 2'd0, "R6 floor then one up", 0);
    upd(32'h44, 1'b1, 2'd0); look(32'h44, 2'd0, "R6 second up", 1);
  endtask

  task automatic t_slots();
    upd(32'h48, 1'b1, 2'd3);
    upd(32'h48, 1'b1, 2'd3);
    look(32'h48, 2'd3, "R4 trained slot", 1);
    look(32'h48, 2'd0, "R4 slot0", 0);
    look(32'h48, 2'd1, "R4 slot1", 0);
    look(32'h48, 2'd2, "R4 slot2", 0);
  endtask

  task automatic t_rows();
    look(32'h48 + ROW_SPAN, 2'd3, "R3 high alias", 1);
    look(32'h4B, 2'd3, "R3 low bits", 1);
    look(32'h4C, 2'd3, "R3 next row", 0);
  endtask

  task automatic t_upd_hist();
    set_hist(2'd3);
    upd(32'h50, 1'b1, 2'd1);
    upd(32'h50, 1'b1, 2'd1);
    look(32'h50, 2'd1, "R7 returned hist slot", 1);
    look(32'h50, 2'd3, "R7 live hist slot", 0);
  endtask

  task automatic t_pair_11();
    int miss;
    int miss_first;
    logic act;
    miss = 0; miss_first = 0;
    for (int it = 0; it < 4; it++) begin
      act = (it % 2 == 0);
      b_lk_pc = 32'h100; #1;
      if (b_lk_taken != act) begin miss++; if (it == 0) miss_first++; end
      b_upd_pc = 32'h100; b_upd_hist = b_lk_hist; b_upd_taken = act; b_upd_valid = 1'b1;
      @(posedge clk); #1; b_upd_valid = 1'b0;
      b_lk_pc = 32'h10C; #1;
      if (b_lk_taken != act) begin miss++; if (it == 0) miss_first++; end
      b_upd_pc = 32'h10C; b_upd_hist = b_lk_hist; b_upd_taken = act; b_upd_valid = 1'b1;
      @(posedge clk); #1; b_upd_valid = 1'b0;
    end
    chk("R8 misses in first pass", miss_first, 2);
    chk("R8 total misses", miss, 2);
  endtask

  initial begin
    tests_run = 0; tests_failed = 0;
    upd_valid = 1'b0; upd_pc = '0; upd_hist = '0; upd_taken = 1'b0; lk_pc = '0;
    b_upd_valid = 1'b0; b_upd_pc = '0; b_upd_hist = '0; b_upd_taken = 1'b0; b_lk_pc = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_history();
    t_count_up();
    t_count_down();
    t_slots();
    t_rows();
    t_upd_hist();
    t_pair_11();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule